// File: doc/BRIEF.md
# Byte-Lane Host Port with Command Register File

This block is the randomly addressed side of a 4096 x 16 buffer memory. A synchronous host interface reaches two targets through the same address and data pins. When the memory select is high, it reads or writes the word array. Two byte-lane enables control the low and high bytes of a word independently. When the register select is high, it reads or writes a small command register file instead.

The register file holds two buffer start pointers and two buffer end pointers. It also holds a control word and a read-only pair of end-of-buffer flags. The pointers and the control word are exported continuously to a neighbouring sequential-pointer block. That block returns one-cycle set pulses for the two flags. The host clears a flag by writing a zero into the matching low bit of the control word. Raising both selects at once is a protocol violation: it is reported on an error output and no access is made.

Read data is registered and appears one clock after the request, qualified by a valid strobe.

Top module: `hostport_top`

## Requirements
- R1: With `mem_sel`=1, `reg_sel`=0 and `rd_wr`=0, the word on `wdata` is written at `addr` on the clock edge. With `rd_wr`=1 and `out_en`=1, the stored word appears on `rdata` in the cycle after the request edge.
- R2: On a memory write, `lane_en[0]` gates bits [7:0] and `lane_en[1]` gates bits [15:8]. A disabled lane leaves that byte of the stored word unchanged.
- R3: On a memory read, a byte whose lane enable was 0 at the request returns zero on `rdata`, and an enabled lane returns the stored byte.
- R4: When `mem_sel` and `reg_sel` are both 1, `sel_err` is 1 in the following cycle. In that case no memory or register write happens and `rdata_vld` stays 0.
- R5: With `reg_sel`=1 and `mem_sel`=0, register addresses 0, 1, 2 and 3 hold start1, end1, start2 and end2. Each is 12 bits, written from `wdata[11:0]`. The registers read back in bits [11:0] and drive `buf_start1`, `buf_end1`, `buf_start2` and `buf_end2` from the edge after the write.
- R6: Register address 5 is a 13-bit control word, written from `wdata[12:0]`, read back, and driven on `ctrl_word`. Writing 0 into bit 0 clears `eob_flag[0]`, and 0 into bit 1 clears `eob_flag[1]`. Writing 1 leaves the flag as it is.
- R7: A 1 on `flag_set[i]` sets `eob_flag[i]` at the next edge, and a set wins over a clear in the same cycle. Register address 4 reads the flags in bits [1:0], with every other bit zero.
- R8: `rdata_vld` is 1 only in the cycle after a read request (`rd_wr`=1, `out_en`=1, exactly one select high). At all other times `rdata_vld` is 0 and `rdata` is zero.
- R9: While `rst_n` is low, every register, both flags, `sel_err` and `rdata_vld` are zero. Release of reset takes effect two clock edges after `rst_n` rises.
- R10: Register addresses 6 and 7 read as zero, and writes to addresses 4, 6 and 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_sel | input | 1 | Selects the word array |
| reg_sel | input | 1 | Selects the command register file |
| rd_wr | input | 1 | 1 = read, 0 = write |
| out_en | input | 1 | Allows read data to be returned |
| lane_en | input | 2 | Byte-lane enables, bit 0 low byte, bit 1 high byte |
| addr | input | 12 | Word address; bits [2:0] pick a register |
| wdata | input | 16 | Write data |
| flag_set | input | 2 | Set pulses for the two end-of-buffer flags |
| rdata | output | 16 | Registered read data |
| rdata_vld | output | 1 | Read data valid |
| sel_err | output | 1 | Both selects were high in the previous cycle |
| buf_start1 | output | 12 | Buffer 1 start pointer |
| buf_end1 | output | 12 | Buffer 1 end pointer |
| buf_start2 | output | 12 | Buffer 2 start pointer |
| buf_end2 | output | 12 | Buffer 2 end pointer |
| ctrl_word | output | 13 | Control register contents |
| eob_flag | output | 2 | End-of-buffer flags, 1 = reached |

## Verification
The array is exercised with full-word writes at both ends of the address space and in the middle. This shows up a dropped or swapped address bit. Single-lane writes of all-ones over a known pattern, and single-lane reads, tell a lane mix-up apart from a missing mask. Register traffic covers every register address, and unused and read-only addresses are checked by read-back. Flag traffic sends set pulses, zero and one writes to the control word, and a set and a clear in the same cycle, so that the clear polarity and the set-over-clear priority can each fail on their own.

// File: rtl/hp_pkg.sv
package hp_pkg;
  localparam int unsigned HP_AW    = 12;
  localparam int unsigned HP_DW    = 16;
  localparam int unsigned HP_LANEW = 8;
  localparam int unsigned HP_RAW   = 3;
  localparam int unsigned HP_CTLW  = 13;
  localparam int unsigned HP_NFLAG = 2;

  localparam logic [HP_RAW-1:0] RA_START1 = 3'd0;
  localparam logic [HP_RAW-1:0] RA_END1   = 3'd1;
  localparam logic [HP_RAW-1:0] RA_START2 = 3'd2;
  localparam logic [HP_RAW-1:0] RA_END2   = 3'd3;
  localparam logic [HP_RAW-1:0] RA_FLAGS  = 3'd4;
  localparam logic [HP_RAW-1:0] RA_CTRL   = 3'd5;

  typedef struct packed {
    logic mem_we;
    logic mem_re;
    logic reg_we;
    logic reg_re;
    logic conflict;
  } hp_dec_t;
endpackage

// File: rtl/hp_decode.sv
module hp_decode
  import hp_pkg::*;
(
  input  logic    mem_sel,
  input  logic    reg_sel,
  input  logic    rd_wr,
  output hp_dec_t dec
);
  logic mem_only;
  logic reg_only;

  always_comb begin
    mem_only     = mem_sel & ~reg_sel;
    reg_only     = reg_sel & ~mem_sel;
    dec.mem_we   = mem_only & ~rd_wr;
    dec.mem_re   = mem_only &  rd_wr;
    dec.reg_we   = reg_only & ~rd_wr;
    dec.reg_re   = reg_only &  rd_wr;
    dec.conflict = mem_sel & reg_sel;
  end
endmodule

// File: rtl/hp_mem.sv
module hp_mem #(
  parameter int unsigned AW    = hp_pkg::HP_AW,
  parameter int unsigned DW    = hp_pkg::HP_DW,
  parameter int unsigned LANEW = hp_pkg::HP_LANEW
) (
  input  logic              clk,
  input  logic              we,
  input  logic              re,
  input  logic [AW-1:0]     addr,
  input  logic [DW-1:0]     wdata,
  input  logic [DW/LANEW-1:0] lane_en,
  output logic [DW-1:0]     rdata_q
);
  localparam int unsigned DEPTH  = 1 << AW;
  localparam int unsigned NLANES = DW / LANEW;

  for (genvar g = 0; g < NLANES; g++) begin : g_lane
    logic [LANEW-1:0] store [DEPTH];
    logic             wr_lane;

    assign wr_lane = we & lane_en[g];

    always_ff @(posedge clk) begin
      if (wr_lane) begin
        store[addr] <= wdata[g*LANEW +: LANEW];
      end
    end

    always_ff @(posedge clk) begin
      if (re) begin
        rdata_q[g*LANEW +: LANEW] <= store[addr];
      end
    end
  end
endmodule

// File: rtl/hp_cmd_regs.sv
module hp_cmd_regs
  import hp_pkg::*;
#(
  parameter int unsigned AW    = HP_AW,
  parameter int unsigned RAW   = HP_RAW,
  parameter int unsigned CTLW  = HP_CTLW,
  parameter int unsigned NFLAG = HP_NFLAG
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [RAW-1:0]   addr,
  input  logic [CTLW-1:0]  wdata,
  input  logic [NFLAG-1:0] flag_set,
  output logic [CTLW-1:0]  rd_data,
  output logic [AW-1:0]    start1,
  output logic [AW-1:0]    end1,
  output logic [AW-1:0]    start2,
  output logic [AW-1:0]    end2,
  output logic [CTLW-1:0]  ctrl,
  output logic [NFLAG-1:0] eob
);
  logic [AW-1:0]    start1_d, end1_d, start2_d, end2_d;
  logic [CTLW-1:0]  ctrl_d;
  logic [NFLAG-1:0] eob_d;
  logic [NFLAG-1:0] eob_clr;
  logic             ctrl_wr;

  always_comb begin
    start1_d = start1;
    end1_d   = end1;
    start2_d = start2;
    end2_d   = end2;
    ctrl_d   = ctrl;
    ctrl_wr  = we && (addr == RA_CTRL);
    if (we) begin
      unique case (addr)
        RA_START1: start1_d = wdata[AW-1:0];
        RA_END1:   end1_d   = wdata[AW-1:0];
        RA_START2: start2_d = wdata[AW-1:0];
        RA_END2:   end2_d   = wdata[AW-1:0];
        RA_CTRL:   ctrl_d   = wdata;
        default:   ;
      endcase
    end
    eob_clr = ctrl_wr ? ~wdata[NFLAG-1:0] : '0;
    eob_d   = (eob & ~eob_clr) | flag_set;
  end

  always_comb begin
    rd_data = '0;
    unique case (addr)
      RA_START1: rd_data[AW-1:0]    = start1;
      RA_END1:   rd_data[AW-1:0]    = end1;
      RA_START2: rd_data[AW-1:0]    = start2;
      RA_END2:   rd_data[AW-1:0]    = end2;
      RA_FLAGS:  rd_data[NFLAG-1:0] = eob;
      RA_CTRL:   rd_data            = ctrl;
      default:   rd_data            = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start1 <= '0;
      end1   <= '0;
      start2 <= '0;
      end2   <= '0;
      ctrl   <= '0;
      eob    <= '0;
    end else begin
      start1 <= start1_d;
      end1   <= end1_d;
      start2 <= start2_d;
      end2   <= end2_d;
      ctrl   <= ctrl_d;
      eob    <= eob_d;
    end
  end

  // R6: a zero written into a control bit clears its flag unless a set arrives
  p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && !wdata[0] && !flag_set[0]) |=> !eob[0]);
  // R7: a set pulse always lands
  p_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    flag_set[1] |=> eob[1]);
  // R5: pointers move only on a register write
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(start1) && $stable(end2));
endmodule

// File: rtl/hostport_top.sv
module hostport_top
  import hp_pkg::*;
#(
  parameter int unsigned AW    = HP_AW,
  parameter int unsigned DW    = HP_DW,
  parameter int unsigned LANEW = HP_LANEW,
  parameter int unsigned CTLW  = HP_CTLW,
  parameter int unsigned NFLAG = HP_NFLAG
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 mem_sel,
  input  logic                 reg_sel,
  input  logic                 rd_wr,
  input  logic                 out_en,
  input  logic [DW/LANEW-1:0]  lane_en,
  input  logic [AW-1:0]        addr,
  input  logic [DW-1:0]        wdata,
  input  logic [NFLAG-1:0]     flag_set,
  output logic [DW-1:0]        rdata,
  output logic                 rdata_vld,
  output logic                 sel_err,
  output logic [AW-1:0]        buf_start1,
  output logic [AW-1:0]        buf_end1,
  output logic [AW-1:0]        buf_start2,
  output logic [AW-1:0]        buf_end2,
  output logic [CTLW-1:0]      ctrl_word,
  output logic [NFLAG-1:0]     eob_flag
);
  localparam int unsigned NLANES = DW / LANEW;

  logic               rst_meta, rst_sync_n;
  hp_dec_t            dec;
  logic [DW-1:0]      mem_q;
  logic [CTLW-1:0]    reg_rd;
  logic               vld_d, vld_q, src_mem_q, src_mem_d;
  logic               err_q;
  logic [NLANES-1:0]  lane_q, lane_d;
  logic [CTLW-1:0]    reg_q, reg_d;
  logic [DW-1:0]      mem_masked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  hp_decode u_dec (
    .mem_sel (mem_sel),
    .reg_sel (reg_sel),
    .rd_wr   (rd_wr),
    .dec     (dec)
  );

  hp_mem #(.AW(AW), .DW(DW), .LANEW(LANEW)) u_mem (
    .clk     (clk),
    .we      (dec.mem_we),
    .re      (dec.mem_re),
    .addr    (addr),
    .wdata   (wdata),
    .lane_en (lane_en),
    .rdata_q (mem_q)
  );

  hp_cmd_regs #(.AW(AW), .RAW(HP_RAW), .CTLW(CTLW), .NFLAG(NFLAG)) u_regs (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .we       (dec.reg_we),
    .addr     (addr[HP_RAW-1:0]),
    .wdata    (wdata[CTLW-1:0]),
    .flag_set (flag_set),
    .rd_data  (reg_rd),
    .start1   (buf_start1),
    .end1     (buf_end1),
    .start2   (buf_start2),
    .end2     (buf_end2),
    .ctrl     (ctrl_word),
    .eob      (eob_flag)
  );

  always_comb begin
    vld_d     = out_en & (dec.mem_re | dec.reg_re);
    src_mem_d = dec.mem_re ? 1'b1 : src_mem_q;
    lane_d    = dec.mem_re ? lane_en : lane_q;
    reg_d     = dec.reg_re ? reg_rd : reg_q;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      vld_q     <= 1'b0;
      err_q     <= 1'b0;
      src_mem_q <= 1'b0;
      lane_q    <= '0;
      reg_q     <= '0;
    end else begin
      vld_q     <= vld_d;
      err_q     <= dec.conflict;
      src_mem_q <= dec.reg_re ? 1'b0 : src_mem_d;
      lane_q    <= lane_d;
      reg_q     <= reg_d;
    end
  end

  for (genvar g = 0; g < NLANES; g++) begin : g_rmask
    assign mem_masked[g*LANEW +: LANEW] =
      lane_q[g] ? mem_q[g*LANEW +: LANEW] : '0;
  end

  always_comb begin
    rdata = '0;
    if (vld_q) begin
      rdata = src_mem_q ? mem_masked : {{(DW-CTLW){1'b0}}, reg_q};
    end
  end

  assign rdata_vld = vld_q;
  assign sel_err   = err_q;

  // R4: both selects high means no write of either kind
  p_excl_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mem_sel && reg_sel) |-> !dec.mem_we && !dec.reg_we);
  // R4: the conflict is reported in the following cycle
  p_err_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mem_sel && reg_sel) |=> sel_err && !rdata_vld);
  // R8: valid data only follows a single-target read request
  p_vld_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rdata_vld |-> $past(rd_wr && out_en && (mem_sel ^ reg_sel)));
endmodule

// File: tb/hostport_top_tb.sv
`timescale 1ns/1ps
module hostport_top_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        mem_sel, reg_sel, rd_wr, out_en;
  logic [1:0]  lane_en, flag_set;
  logic [11:0] addr;
  logic [15:0] wdata;
  logic [15:0] rdata;
  logic        rdata_vld, sel_err;
  logic [11:0] buf_start1, buf_end1, buf_start2, buf_end2;
  logic [12:0] ctrl_word;
  logic [1:0]  eob_flag;

  int n_chk = 0;
  int n_bad = 0;
  string cur_req = "R9";

  logic [15:0] mm [4096];
  logic [11:0] m_ptr [4];
  logic [12:0] m_ctrl;
  logic [1:0]  m_flag;
  logic [15:0] e_rdata;
  logic        e_vld, e_err;

  always #5 clk = ~clk;

  hostport_top u_dut (
    .clk(clk), .rst_n(rst_n), .mem_sel(mem_sel), .reg_sel(reg_sel),
    .rd_wr(rd_wr), .out_en(out_en), .lane_en(lane_en), .addr(addr),
    .wdata(wdata), .flag_set(flag_set), .rdata(rdata), .rdata_vld(rdata_vld),
    .sel_err(sel_err), .buf_start1(buf_start1), .buf_end1(buf_end1),
    .buf_start2(buf_start2), .buf_end2(buf_end2), .ctrl_word(ctrl_word),
    .eob_flag(eob_flag)
  );

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", cur_req, what, act, exp);
    end
  endtask

  task automatic compare_all();
    chk("rdata", rdata, e_rdata);
    chk("rdata_vld", rdata_vld, e_vld);
    chk("sel_err", sel_err, e_err);
    chk("buf_start1", buf_start1, m_ptr[0]);
    chk("buf_end1", buf_end1, m_ptr[1]);
    chk("buf_start2", buf_start2, m_ptr[2]);
    chk("buf_end2", buf_end2, m_ptr[3]);
    chk("ctrl_word", ctrl_word, m_ctrl);
    chk("eob_flag", eob_flag, m_flag);
  endtask

  task automatic model_reset();
    for (int i = 0; i < 4; i++) m_ptr[i] = '0;
    m_ctrl = '0; m_flag = '0; e_rdata = '0; e_vld = 1'b0; e_err = 1'b0;
  endtask

  function automatic logic [15:0] reg_read(input logic [2:0] a);
    if (a < 3'd4) return {4'b0, m_ptr[a]};
    if (a == 3'd4) return {14'b0, m_flag};
    if (a == 3'd5) return {3'b0, m_ctrl};
    return 16'h0;
  endfunction

  task automatic step(input logic ms, input logic rs, input logic rw, input logic oe,
                      input logic [1:0] ln, input logic [11:0] a, input logic [15:0] d,
                      input logic [1:0] fs);
    logic [15:0] v;
    logic [1:0]  clr;
    @(negedge clk);
    mem_sel = ms; reg_sel = rs; rd_wr = rw; out_en = oe;
    lane_en = ln; addr = a; wdata = d; flag_set = fs;
    @(posedge clk);
    v = 16'h0; clr = 2'b00;
    if (ms && !rs) begin
      if (rw) begin
        v[7:0]  = ln[0] ? mm[a][7:0]  : 8'h00;
        v[15:8] = ln[1] ? mm[a][15:8] : 8'h00;
      end else begin
        if (ln[0]) mm[a][7:0]  = d[7:0];
        if (ln[1]) mm[a][15:8] = d[15:8];
      end
    end
    if (rs && !ms) begin
      if (rw) v = reg_read(a[2:0]);
      else if (a[2:0] < 3'd4) m_ptr[a[2:0]] = d[11:0];
      else if (a[2:0] == 3'd5) begin
        m_ctrl = d[12:0];
        clr = ~d[1:0];
      end
    end
    m_flag  = (m_flag & ~clr) | fs;
    e_err   = ms && rs;
    e_vld   = rw && oe && (ms ^ rs);
    e_rdata = e_vld ? v : 16'h0;
    #1;
    compare_all();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 1, 0, 2'b00, 12'h0, 16'h0, 2'b00);
  endtask

  task automatic mwr(input logic [11:0] a, input logic [15:0] d, input logic [1:0] ln);
    step(1, 0, 0, 0, ln, a, d, 2'b00);
  endtask
  task automatic mrd(input logic [11:0] a, input logic [1:0] ln);
    step(1, 0, 1, 1, ln, a, 16'h0, 2'b00);
  endtask
  task automatic rwr(input logic [2:0] a, input logic [15:0] d, input logic [1:0] fs);
    step(0, 1, 0, 0, 2'b11, {9'h0, a}, d, fs);
  endtask
  task automatic rrd(input logic [2:0] a);
    step(0, 1, 1, 1, 2'b11, {9'h0, a}, 16'h0, 2'b00);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; mem_sel = 0; reg_sel = 0; rd_wr = 1; out_en = 0;
    lane_en = 0; addr = 0; wdata = 0; flag_set = 0;
    model_reset();
    // R9: reset state
    #23; compare_all();
    @(negedge clk); rst_n = 1'b1;
    idle(3);

    // R1: full words at both ends and middle
    cur_req = "R1";
    mwr(12'h000, 16'h1234, 2'b11);
    mwr(12'hFFF, 16'hBEEF, 2'b11);
    mwr(12'h5A5, 16'hC3A5, 2'b11);
    mwr(12'h001, 16'h0F0F, 2'b11);
    mrd(12'h000, 2'b11); mrd(12'hFFF, 2'b11); mrd(12'h5A5, 2'b11); mrd(12'h001, 2'b11);

    // R2: single-lane writes
    cur_req = "R2";
    mwr(12'h001, 16'hFFFF, 2'b01);
    mrd(12'h001, 2'b11);
    mwr(12'h5A5, 16'hFFFF, 2'b10);
    mrd(12'h5A5, 2'b11);
    mwr(12'h000, 16'hFFFF, 2'b00);
    mrd(12'h000, 2'b11);

    // R3: single-lane reads
    cur_req = "R3";
    mrd(12'hFFF, 2'b01); mrd(12'hFFF, 2'b10); mrd(12'hFFF, 2'b00);

    // R8: read without output enable, and idle after a read
    cur_req = "R8";
    step(1, 0, 1, 0, 2'b11, 12'hFFF, 16'h0, 2'b00);
    mrd(12'h001, 2'b11);
    idle(1);

    // R4: both selects, write attempted to memory and register
    cur_req = "R4";
    step(1, 1, 0, 0, 2'b11, 12'h000, 16'h7777, 2'b00);
    step(1, 1, 1, 1, 2'b11, 12'h000, 16'h0, 2'b00);
    mrd(12'h000, 2'b11);
    rrd(3'd0);

    // R5: pointer registers
    cur_req = "R5";
    rwr(3'd0, 16'hFABC, 2'b00);
    rwr(3'd1, 16'h0FFF, 2'b00);
    rwr(3'd2, 16'h0800, 2'b00);
    rwr(3'd3, 16'h0001, 2'b00);
    rrd(3'd0); rrd(3'd1); rrd(3'd2); rrd(3'd3);

    // R10: unused and read-only addresses
    cur_req = "R10";
    rwr(3'd6, 16'hFFFF, 2'b00);
    rwr(3'd7, 16'hFFFF, 2'b00);
    rwr(3'd4, 16'h0003, 2'b00);
    rrd(3'd6); rrd(3'd7); rrd(3'd4); rrd(3'd0);

    // R7: set pulses and flag read-back
    cur_req = "R7";
    step(0, 0, 1, 0, 2'b00, 12'h0, 16'h0, 2'b01);
    rrd(3'd4);
    step(0, 0, 1, 0, 2'b00, 12'h0, 16'h0, 2'b10);
    rrd(3'd4);

    // R6: control writes, clear polarity per bit
    cur_req = "R6";
    rwr(3'd5, 16'h1FFF, 2'b00);
    rwr(3'd5, 16'h1FFE, 2'b00);
    rrd(3'd4); rrd(3'd5);
    rwr(3'd5, 16'h0001, 2'b00);
    rrd(3'd4);

    // R7: set wins over clear in the same cycle
    cur_req = "R7";
    rwr(3'd5, 16'h0000, 2'b11);
    rrd(3'd4);
    rwr(3'd5, 16'h0000, 2'b00);

    // R9: reset mid-run clears registers and flags
    cur_req = "R9";
    step(0, 0, 1, 0, 2'b00, 12'h0, 16'h0, 2'b11);
    mrd(12'h5A5, 2'b11);
    @(negedge clk); rst_n = 1'b0; #2;
    model_reset();
    compare_all();
    @(negedge clk); rst_n = 1'b1;
    idle(3);
    rrd(3'd4); rrd(3'd0);

    finish_run();
  end
endmodule